// File: doc/BRIEF.md
# Constant-Off-Time Current Limiter with Blanking

This block sits between the load-current comparators of an H-bridge and its gate control. While the bridge is commanded to drive, a trip of the current-limit comparator makes the block request high impedance on both legs for a fixed number of clock cycles. Afterwards the legs return to their commanded state and a new on period begins. The load current therefore settles into a sawtooth just below the limit threshold.

Every output transition opens a blanking window. During this window the limit comparator is ignored, so that switching spikes are not read as overload. The short-circuit comparator is never blanked. A short produces a one-cycle fault pulse, and the neighbouring fault logic latches it into a permanent tristate.

Two junction temperature flags are also handled. The foldback flag makes the threshold-select output choose the reduced limit reference. The shutdown flag produces a one-cycle overtemperature fault pulse. The off time and the blanking time are given in nanoseconds and converted to cycle counts from the clock frequency parameter.

Top module: `coff_limiter`

## Requirements
- R1: While `rst_n` is low, `force_hiz`, `short_flt`, `ot_flt` and `thr_sel` are all 0.
- R2: When `cmd_on` is 1 and `lim_trip` is sampled 1 at a clock edge, with neither blanking nor off time active at that edge, `force_hiz` is 1 from that edge on for exactly OFF_CYC cycles, where OFF_CYC = OFF_NS*CLK_MHZ/1000.
- R3: A `lim_trip` sampled while blanking is active has no effect on `force_hiz`.
- R4: Blanking covers the edge at which `edge_strobe` is sampled 1 and the BLANK_CYC edges that follow, where BLANK_CYC = BLANK_NS*CLK_MHZ/1000. A trip at the next edge after those is accepted.
- R5: A `lim_trip` that occurs while the off time runs neither extends nor restarts it.
- R6: The end of the off time starts blanking by itself. A trip held through the off time is accepted again only BLANK_CYC+1 edges after `force_hiz` falls.
- R7: A rise of `short_trip` while `cmd_on` is 1 gives a one-cycle `short_flt` pulse one cycle later, including during blanking. A held short gives only one pulse.
- R8: A rise of `temp_shut` gives a one-cycle `ot_flt` pulse one cycle later, once per rise.
- R9: `thr_sel` equals `temp_fold` delayed by one cycle. The value 1 selects the reduced limit and 0 selects the normal limit.
- R10: While `cmd_on` is 0, limit trips are ignored, no `short_flt` is raised and `force_hiz` is 0 from the next cycle on. Dropping `cmd_on` during the off time ends it at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_on | input | 1 | Bridge is commanded to drive (not tristate and not asleep) |
| edge_strobe | input | 1 | One-cycle strobe at every commanded output transition |
| lim_trip | input | 1 | Current-limit comparator output |
| short_trip | input | 1 | Short-circuit comparator output |
| temp_fold | input | 1 | Junction is in the foldback temperature region |
| temp_shut | input | 1 | Junction is at or above the shutdown temperature |
| force_hiz | output | 1 | Request to tristate both legs for the off time |
| short_flt | output | 1 | One-cycle short-fault pulse |
| ot_flt | output | 1 | One-cycle overtemperature fault pulse |
| thr_sel | output | 1 | Limit reference select: 0 normal, 1 reduced |

## Verification
The bench holds `lim_trip` high across a whole off time and the blanking window that follows it.

- A design that lets a trip extend the off time would show a longer high-impedance pulse.
- A design that fails to re-blank when the off time ends would re-trip at once.
- A design whose blanking window is one cycle off would accept or reject the trip at the wrong edge.

It also raises a short during blanking, where a design that blanked both comparators would stay silent. It drops `cmd_on` in the middle of an off time, where a design that kept counting would hold the legs off after the command was gone.

// File: rtl/coff_pkg.sv
package coff_pkg;

    // Limit reference choice driven on thr_sel
    typedef enum logic {
        THR_NORMAL  = 1'b0,
        THR_REDUCED = 1'b1
    } thr_sel_e;

    // Edge-to-pulse stage state
    typedef struct packed {
        logic prev;
        logic pulse;
    } pulse_st_t;

    // Convert a duration in ns to whole clock cycles at the given MHz
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
        return (ns * mhz) / 1000;
    endfunction

endpackage

// File: rtl/coff_blank_timer.sv
module coff_blank_timer #(
    parameter int unsigned CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic start,
    output logic busy
);
    localparam int unsigned W = $clog2(CYC + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } blank_st_t;

    blank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (start) begin
            st_d.cnt = W'(CYC);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // The transition cycle itself is masked as well
    assign busy = (st_q.cnt != '0) | (run & start);

    // R4: a transition always leaves a running window behind it
    assert_blank_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && start) |=> busy);

endmodule

// File: rtl/coff_off_timer.sv
module coff_off_timer #(
    parameter int unsigned CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic trip,
    input  logic mask,
    output logic active,
    output logic last
);
    localparam int unsigned W = $clog2(CYC + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } off_st_t;

    off_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - W'(1);
        end else if (trip && !mask) begin
            st_d.cnt = W'(CYC);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.cnt != '0);
    assign last   = (st_q.cnt == W'(1));

    // R2: an accepted trip from idle always opens an off period
    assert_trip_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !active && trip && !mask) |=> active);

endmodule

// File: rtl/coff_pulse.sv
module coff_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic lvl,
    output logic pulse
);
    import coff_pkg::*;

    pulse_st_t st_d, st_q;
    logic      gated;

    assign gated = en & lvl;

    always_comb begin
        st_d       = st_q;
        st_d.prev  = gated;
        st_d.pulse = gated & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.pulse;

    // R7: a fault indication never lasts more than one cycle
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/coff_limiter.sv
module coff_limiter #(
    parameter int unsigned CLK_MHZ  = 250,
    parameter int unsigned OFF_NS   = 20500,
    parameter int unsigned BLANK_NS = 16500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_on,
    input  logic edge_strobe,
    input  logic lim_trip,
    input  logic short_trip,
    input  logic temp_fold,
    input  logic temp_shut,
    output logic force_hiz,
    output logic short_flt,
    output logic ot_flt,
    output logic thr_sel
);
    import coff_pkg::*;

    localparam int unsigned OFF_CYC   = ns_to_cyc(OFF_NS, CLK_MHZ);
    localparam int unsigned BLANK_CYC = ns_to_cyc(BLANK_NS, CLK_MHZ);

    typedef struct packed {
        thr_sel_e thr;
    } top_st_t;

    logic    blank_act;
    logic    off_act;
    logic    off_last;
    logic    blank_start;
    top_st_t top_d, top_q;

    // Leaving the off period switches the legs, so it re-arms blanking
    assign blank_start = edge_strobe | off_last;

    coff_blank_timer #(.CYC(BLANK_CYC)) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cmd_on),
        .start (blank_start),
        .busy  (blank_act)
    );

    coff_off_timer #(.CYC(OFF_CYC)) u_off (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cmd_on),
        .trip   (lim_trip),
        .mask   (blank_act),
        .active (off_act),
        .last   (off_last)
    );

    coff_pulse u_short (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cmd_on),
        .lvl   (short_trip),
        .pulse (short_flt)
    );

    coff_pulse u_ot (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (1'b1),
        .lvl   (temp_shut),
        .pulse (ot_flt)
    );

    always_comb begin
        top_d     = top_q;
        top_d.thr = temp_fold ? THR_REDUCED : THR_NORMAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign force_hiz = off_act;
    assign thr_sel   = top_q.thr;

    // R3: with blanking active and no off period, no off period can begin
    assert_blank_masks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_act && !off_act) |=> !force_hiz);

    // R5: the final off cycle is always followed by release
    assert_no_extend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        off_last |=> !force_hiz);

    // R6: finishing the off period leaves blanking running
    assert_reblank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (off_last && cmd_on) |=> blank_act);

    // R7: a short fault only follows a cycle in which drive was commanded
    assert_short_needs_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        short_flt |-> $past(cmd_on));

    // R8: an overtemperature pulse only follows a set shutdown flag
    assert_ot_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flt |-> $past(temp_shut));

    // R9: threshold select tracks the foldback flag by one cycle
    assert_thr_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(temp_fold) |-> thr_sel);

    // R10: no tristate request survives a dropped command
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_on |=> !force_hiz);

endmodule

// File: tb/test_coff_limiter.sv
module test_coff_limiter;

    localparam int OFF   = 20;   // 20500 ns at 1 MHz count basis
    localparam int BLANK = 16;   // 16500 ns at 1 MHz count basis

    typedef struct {
        logic  hiz;
        logic  sc;
        logic  ot;
        logic  thr;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_on = 1'b0, edge_strobe = 1'b0, lim_trip = 1'b0;
    logic short_trip = 1'b0, temp_fold = 1'b0, temp_shut = 1'b0;
    logic force_hiz, short_flt, ot_flt, thr_sel;

    int   tests = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    coff_limiter #(.CLK_MHZ(1), .OFF_NS(20500), .BLANK_NS(16500)) i_coff_limiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_on      (cmd_on),
        .edge_strobe (edge_strobe),
        .lim_trip    (lim_trip),
        .short_trip  (short_trip),
        .temp_fold   (temp_fold),
        .temp_shut   (temp_shut),
        .force_hiz   (force_hiz),
        .short_flt   (short_flt),
        .ot_flt      (ot_flt),
        .thr_sel     (thr_sel)
    );

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Monitor: compare results at each falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(force_hiz, e.hiz, e.tag, "force_hiz");
            chk(short_flt, e.sc,  e.tag, "short_flt");
            chk(ot_flt,    e.ot,  e.tag, "ot_flt");
            chk(thr_sel,   e.thr, e.tag, "thr_sel");
        end
    end

    // Driver: inputs are already set; push what the next edge must produce
    task automatic tick(input logic eh, input logic es, input logic eo, input string tag);
        exp_t e;
        e.hiz = eh; e.sc = es; e.ot = eo; e.thr = temp_fold; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic hold(input int n, input logic eh, input string tag);
        for (int i = 0; i < n; i++) tick(eh, 1'b0, 1'b0, tag);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(force_hiz, 1'b0, "R1", "force_hiz");
        chk(short_flt, 1'b0, "R1", "short_flt");
        chk(ot_flt,    1'b0, "R1", "ot_flt");
        chk(thr_sel,   1'b0, "R1", "thr_sel");
        #1;
        rst_n = 1'b1;
        hold(2, 1'b0, "R1");

        // R10: idle command ignores limit and short
        lim_trip = 1'b1;
        hold(3, 1'b0, "R10");
        short_trip = 1'b1;
        tick(1'b0, 1'b0, 1'b0, "R10");
        short_trip = 1'b0;
        lim_trip = 1'b0;
        tick(1'b0, 1'b0, 1'b0, "R10");

        // R2 / R5 / R6: trip held across off time and re-blanking
        cmd_on = 1'b1;
        hold(2, 1'b0, "R2");
        lim_trip = 1'b1;
        tick(1'b1, 1'b0, 1'b0, "R2");
        hold(OFF - 1, 1'b1, "R5");
        tick(1'b0, 1'b0, 1'b0, "R2");
        hold(BLANK, 1'b0, "R6");
        tick(1'b1, 1'b0, 1'b0, "R6");
        lim_trip = 1'b0;
        hold(OFF - 1, 1'b1, "R2");
        tick(1'b0, 1'b0, 1'b0, "R2");
        hold(BLANK, 1'b0, "R2");

        // R3 / R4: blanking window after a transition strobe
        edge_strobe = 1'b1;
        lim_trip = 1'b1;
        tick(1'b0, 1'b0, 1'b0, "R3");
        edge_strobe = 1'b0;
        hold(BLANK, 1'b0, "R4");
        tick(1'b1, 1'b0, 1'b0, "R4");
        lim_trip = 1'b0;
        hold(OFF - 1, 1'b1, "R4");
        tick(1'b0, 1'b0, 1'b0, "R4");
        hold(BLANK, 1'b0, "R4");

        // R7: short during blanking, held short pulses once
        edge_strobe = 1'b1;
        tick(1'b0, 1'b0, 1'b0, "R7");
        edge_strobe = 1'b0;
        short_trip = 1'b1;
        tick(1'b0, 1'b1, 1'b0, "R7");
        tick(1'b0, 1'b0, 1'b0, "R7");
        short_trip = 1'b0;
        tick(1'b0, 1'b0, 1'b0, "R7");
        hold(BLANK, 1'b0, "R7");

        // R10: dropping the command ends the off time
        lim_trip = 1'b1;
        tick(1'b1, 1'b0, 1'b0, "R10");
        lim_trip = 1'b0;
        tick(1'b1, 1'b0, 1'b0, "R10");
        cmd_on = 1'b0;
        tick(1'b0, 1'b0, 1'b0, "R10");
        tick(1'b0, 1'b0, 1'b0, "R10");
        cmd_on = 1'b1;
        lim_trip = 1'b1;
        tick(1'b1, 1'b0, 1'b0, "R10");
        lim_trip = 1'b0;
        hold(OFF - 1, 1'b1, "R10");
        tick(1'b0, 1'b0, 1'b0, "R10");
        hold(BLANK, 1'b0, "R10");

        // R8: overtemperature pulse per rise
        temp_shut = 1'b1;
        tick(1'b0, 1'b0, 1'b1, "R8");
        tick(1'b0, 1'b0, 1'b0, "R8");
        temp_shut = 1'b0;
        tick(1'b0, 1'b0, 1'b0, "R8");
        temp_shut = 1'b1;
        tick(1'b0, 1'b0, 1'b1, "R8");
        temp_shut = 1'b0;
        tick(1'b0, 1'b0, 1'b0, "R8");

        // R9: threshold select follows foldback
        temp_fold = 1'b1;
        hold(2, 1'b0, "R9");
        temp_fold = 1'b0;
        hold(2, 1'b0, "R9");

        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule